// File: doc/BRIEF.md
# Slave Clock Ratio Auto-Detector

This block sits beside the serial port of an audio converter that runs as a clock slave. It receives the master clock, the bit clock and the frame (left/right) clock from outside. It samples all three in a fast reference-clock domain. Over each frame period it counts master-clock rising edges, bit-clock rising edges and reference cycles. From those counts it works out whether the converter runs at single or double speed, whether the internal divider must take the high or the low master-clock option, and whether the ratio belongs to the triple family (192/384/768) rather than the binary family (128/256/512).

A result is published only after several consecutive frames classify the same way, and a lock flag shows that the published result is current. A frame that disagrees drops the lock. Measurements that do not match any supported combination keep the last good configuration on the outputs. A separate watchdog on the master clock raises a clock-stopped flag, which the converter uses to enter power-down. While that flag is up, all tracking restarts.

A frame period runs from one falling edge of the frame clock to the next. The ratios 256 and 384 occur in both speed modes, so the block separates them by frame rate: a frame shorter than `FS_SPLIT` reference cycles means double speed.

Top module: `slave_ratio_detect`

## Requirements
- R1: While reset is applied and right after it, `locked`, `clockStopped`, `doubleSpeed`, `divHigh` and `tripleRatio` are all 0.
- R2: `locked` rises only after `AGREE_FRAMES` (3) consecutive complete frame periods give the same valid classification. The first falling frame edge after reset or after a clock stop only starts measuring.
- R3: Output encoding is `doubleSpeed` 1 for double speed and `divHigh` 1 for the high option. The high option is 512x/768x at single speed and 256x/384x at double speed. `tripleRatio` is 1 for 192x, 384x and 768x. 128x gives {1,0,0}, 192x {1,0,1}, 512x {0,1,0}, 768x {0,1,1}, where each triple is {doubleSpeed,divHigh,tripleRatio}.
- R4: For 256x and 384x, a frame of fewer than `FS_SPLIT` (800) reference cycles selects double speed with the high divider option. Otherwise the block selects single speed with the low option.
- R5: A bit-clock count of 64 (±2) per frame is accepted for every ratio. A count of 48 (±2) is accepted only for the triple family. Any other count is unsupported.
- R6: A master-clock count within ±`TOL` (2) of a legal ratio is classified as that ratio. A count 3 or more away from every legal ratio is unsupported.
- R7: While measurements are unsupported, `locked` stays 0 and the three configuration outputs keep the last value published under lock.
- R8: Once locked, the first frame whose classification differs from the previous one, or is unsupported, clears `locked`.
- R9: `clockStopped` rises after `STOP_CYCLES` (256) reference cycles with no synchronized master-clock edge, and falls after the next edge. While it is high, `locked` is cleared and tracking restarts.
- R10: 128x and 192x are supported only with a double-speed frame rate, and 512x and 768x only with a single-speed frame rate. Any other pairing is unsupported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic and counting runs on it |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| mclkIn | input | 1 | External master clock, asynchronous |
| bclkIn | input | 1 | External bit clock, asynchronous |
| fclkIn | input | 1 | External frame clock; a falling edge starts a frame period |
| doubleSpeed | output | 1 | 1 = double-speed mode |
| divHigh | output | 1 | 1 = high master-clock option within the speed mode |
| tripleRatio | output | 1 | 1 = ratio is 192x, 384x or 768x |
| locked | output | 1 | Configuration outputs reflect the current clocks |
| clockStopped | output | 1 | Master clock idle; power-down request |

## Verification
The assertions assume the reference clock is fast enough to see every master-clock level. This means each master-clock high and low phase lasts at least one reference cycle. They also assume the three external clocks change only between reference edges, so the synchronizers keep their relative alignment. The bench drives all three clocks at the falling reference edge and holds each master-clock phase for one to four whole reference cycles. It derives bit and frame clocks from a master-clock phase counter, so the frame edge always coincides with a master-clock rising edge. Random cases pick a legal ratio, a bit count allowed for it, a ±2 deviation and a phase length that keeps 256x and 384x on either side of the frame-rate split.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef struct packed {
    logic dbl;
    logic hi;
    logic triple;
  } cfg_t;

  typedef struct packed {
    logic valid;
    cfg_t cfg;
  } verdict_t;

  // strobes from control to datapath
  typedef struct packed {
    logic notePrev;  // remember this frame's classification
    logic loadCfg;   // publish this frame's classification
  } strobe_t;

  function automatic logic near(input logic [31:0] x, input logic [31:0] t,
                                input logic [31:0] tol);
    return (x + tol >= t) && (x <= t + tol);
  endfunction

  function automatic verdict_t classify(input logic [31:0] mCnt,
                                        input logic [31:0] bCnt,
                                        input logic [31:0] rCnt,
                                        input logic [31:0] split,
                                        input logic [31:0] tol);
    verdict_t v;
    logic fast;
    fast = rCnt < split;
    v = '0;
    if (near(mCnt, 32'd128, tol)) begin
      v.valid = fast;  v.cfg = '{dbl: 1'b1, hi: 1'b0, triple: 1'b0};
    end else if (near(mCnt, 32'd192, tol)) begin
      v.valid = fast;  v.cfg = '{dbl: 1'b1, hi: 1'b0, triple: 1'b1};
    end else if (near(mCnt, 32'd256, tol)) begin
      v.valid = 1'b1;  v.cfg = '{dbl: fast, hi: fast, triple: 1'b0};
    end else if (near(mCnt, 32'd384, tol)) begin
      v.valid = 1'b1;  v.cfg = '{dbl: fast, hi: fast, triple: 1'b1};
    end else if (near(mCnt, 32'd512, tol)) begin
      v.valid = !fast; v.cfg = '{dbl: 1'b0, hi: 1'b1, triple: 1'b0};
    end else if (near(mCnt, 32'd768, tol)) begin
      v.valid = !fast; v.cfg = '{dbl: 1'b0, hi: 1'b1, triple: 1'b1};
    end
    if (!(near(bCnt, 32'd64, tol) || (near(bCnt, 32'd48, tol) && v.cfg.triple)))
      v.valid = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/srd_sync.sv
module srd_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      end else begin
        s1 <= asyncIn[i]; s2 <= s1; s3 <= s2;
      end
    end
    assign cur[i]  = s2;
    assign prev[i] = s3;
  end
endmodule

// File: rtl/srd_datapath.sv
module srd_datapath
  import srd_pkg::*;
#(
  parameter int MCNT_W      = 11,
  parameter int RCNT_W      = 16,
  parameter int STOP_CYCLES = 256,
  parameter int FS_SPLIT    = 800,
  parameter int TOL         = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    mclkIn,
  input  logic    bclkIn,
  input  logic    fclkIn,
  input  strobe_t stb,
  output logic    frameDone,
  output logic    measValid,
  output logic    measSame,
  output logic    mclkEdge,
  output logic    clockStopped,
  output cfg_t    cfgOut
);
  localparam int STOP_W = $clog2(STOP_CYCLES);

  logic [2:0] cur, prev;
  srd_sync #(.W(3)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({fclkIn, bclkIn, mclkIn}),
    .cur(cur), .prev(prev)
  );

  logic mRise, bRise, fFall;
  assign mRise    = cur[0] & ~prev[0];
  assign bRise    = cur[1] & ~prev[1];
  assign fFall    = ~cur[2] & prev[2];
  assign mclkEdge = cur[0] ^ prev[0];

  logic [MCNT_W-1:0] mCnt, bCnt, measM, measB;
  logic [RCNT_W-1:0] rCnt, measR;
  logic [STOP_W-1:0] stopCnt;
  cfg_t prevCfg;
  verdict_t verdict;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mCnt <= '0; bCnt <= '0; rCnt <= '0;
      measM <= '0; measB <= '0; measR <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= fFall;
      if (fFall) begin
        measM <= mCnt; measB <= bCnt; measR <= rCnt;
        mCnt <= {{(MCNT_W-1){1'b0}}, mRise};
        bCnt <= {{(MCNT_W-1){1'b0}}, bRise};
        rCnt <= {{(RCNT_W-1){1'b0}}, 1'b1};
      end else begin
        if (mRise && mCnt != '1) mCnt <= mCnt + 1'b1;
        if (bRise && bCnt != '1) bCnt <= bCnt + 1'b1;
        if (rCnt != '1) rCnt <= rCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopCnt <= '0; clockStopped <= 1'b0;
    end else if (mclkEdge) begin
      stopCnt <= '0; clockStopped <= 1'b0;
    end else if (stopCnt == STOP_W'(STOP_CYCLES - 1)) begin
      clockStopped <= 1'b1;
    end else begin
      stopCnt <= stopCnt + 1'b1;
    end
  end

  assign verdict   = classify(32'(measM), 32'(measB), 32'(measR),
                              32'(FS_SPLIT), 32'(TOL));
  assign measValid = verdict.valid;
  assign measSame  = (verdict.cfg == prevCfg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCfg <= '0; cfgOut <= '0;
    end else begin
      if (stb.notePrev) prevCfg <= verdict.cfg;
      if (stb.loadCfg)  cfgOut  <= verdict.cfg;
    end
  end
endmodule

// File: rtl/srd_control.sv
module srd_control
  import srd_pkg::*;
#(
  parameter int AGREE_FRAMES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameDone,
  input  logic    measValid,
  input  logic    measSame,
  input  logic    clockStopped,
  output strobe_t stb,
  output logic    locked
);
  localparam int SW = $clog2(AGREE_FRAMES + 1);

  logic          primed;
  logic [SW-1:0] streak, streakNext;

  always_comb begin
    stb = '0;
    streakNext = '0;
    if (measValid) begin
      if (measSame && streak != '0)
        streakNext = (streak == SW'(AGREE_FRAMES)) ? streak : streak + 1'b1;
      else
        streakNext = SW'(1);
    end
    if (frameDone && primed && !clockStopped && measValid) begin
      stb.notePrev = 1'b1;
      stb.loadCfg  = (streakNext == SW'(AGREE_FRAMES));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clockStopped) begin
      primed <= 1'b0; streak <= '0; locked <= 1'b0;
    end else if (frameDone) begin
      primed <= 1'b1;
      if (primed) begin
        streak <= streakNext;
        locked <= (streakNext == SW'(AGREE_FRAMES));
      end
    end
  end
endmodule

// File: rtl/slave_ratio_detect.sv
module slave_ratio_detect
  import srd_pkg::*;
#(
  parameter int MCNT_W       = 11,
  parameter int RCNT_W       = 16,
  parameter int STOP_CYCLES  = 256,
  parameter int FS_SPLIT     = 800,
  parameter int TOL          = 2,
  parameter int AGREE_FRAMES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic mclkIn,
  input  logic bclkIn,
  input  logic fclkIn,
  output logic doubleSpeed,
  output logic divHigh,
  output logic tripleRatio,
  output logic locked,
  output logic clockStopped
);
  strobe_t stb;
  cfg_t    cfgOut;
  logic    frameDone, measValid, measSame, mclkEdge;

  srd_datapath #(
    .MCNT_W(MCNT_W), .RCNT_W(RCNT_W), .STOP_CYCLES(STOP_CYCLES),
    .FS_SPLIT(FS_SPLIT), .TOL(TOL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mclkIn(mclkIn), .bclkIn(bclkIn), .fclkIn(fclkIn),
    .stb(stb), .frameDone(frameDone), .measValid(measValid), .measSame(measSame),
    .mclkEdge(mclkEdge), .clockStopped(clockStopped), .cfgOut(cfgOut)
  );

  srd_control #(.AGREE_FRAMES(AGREE_FRAMES)) u_ctl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .measValid(measValid),
    .measSame(measSame), .clockStopped(clockStopped), .stb(stb), .locked(locked)
  );

  assign doubleSpeed = cfgOut.dbl;
  assign divHigh     = cfgOut.hi;
  assign tripleRatio = cfgOut.triple;
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
  parameter int STOP_CYCLES = 256
) (
  input logic clk,
  input logic rstN,
  input logic locked,
  input logic clockStopped,
  input logic doubleSpeed,
  input logic divHigh,
  input logic tripleRatio,
  input logic frameDone,
  input logic measValid,
  input logic measSame,
  input logic mclkEdge
);
  logic [31:0] idle;
  always_ff @(posedge clk) begin
    if (!rstN || mclkEdge) idle <= '0;
    else if (idle < 32'(STOP_CYCLES)) idle <= idle + 1;
  end

  // R2
  lock_after_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(frameDone));

  // R7
  cfg_only_under_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({doubleSpeed, divHigh, tripleRatio}) |-> locked);

  // R8
  drop_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !clockStopped && (!measValid || !measSame)) |=> !locked);

  // R9
  stop_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    clockStopped |-> idle >= 32'(STOP_CYCLES));

  // R9
  stop_clears_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    clockStopped |=> !locked);
endmodule

bind slave_ratio_detect srd_checker #(.STOP_CYCLES(STOP_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .locked(locked), .clockStopped(clockStopped),
  .doubleSpeed(doubleSpeed), .divHigh(divHigh), .tripleRatio(tripleRatio),
  .frameDone(frameDone), .measValid(measValid), .measSame(measSame),
  .mclkEdge(mclkEdge)
);

// File: tb/slave_ratio_detect_test.sv
module slave_ratio_detect_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic mclk = 1'b0, bclk = 1'b0, fclk = 1'b1;
  logic doubleSpeed, divHigh, tripleRatio, locked, clockStopped;
  int total = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;
  logic [2:0] held = 3'b000;

  always #5 clk = ~clk;

  slave_ratio_detect uut (
    .clk(clk), .rstN(rstN), .mclkIn(mclk), .bclkIn(bclk), .fclkIn(fclk),
    .doubleSpeed(doubleSpeed), .divHigh(divHigh), .tripleRatio(tripleRatio),
    .locked(locked), .clockStopped(clockStopped)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] cfgNow();
    return {doubleSpeed, divHigh, tripleRatio};
  endfunction

  // expected classification {valid, cfg} from the requirements
  function automatic logic [3:0] expect_cfg(int L, int bits, int h);
    int legal[6] = '{128, 192, 256, 384, 512, 768};
    int r = 0;
    bit fast = (L * 2 * h) < 800;
    bit v = 1'b0;
    logic [2:0] c = 3'b000;
    foreach (legal[i]) if (L >= legal[i] - 2 && L <= legal[i] + 2) r = legal[i];
    case (r)
      128: begin v = fast;  c = 3'b100; end
      192: begin v = fast;  c = 3'b101; end
      256: begin v = 1'b1;  c = {fast, fast, 1'b0}; end
      384: begin v = 1'b1;  c = {fast, fast, 1'b1}; end
      512: begin v = !fast; c = 3'b010; end
      768: begin v = !fast; c = 3'b011; end
      default: v = 1'b0;
    endcase
    if (!((bits >= 62 && bits <= 66) || (bits >= 46 && bits <= 50 && c[0]))) v = 1'b0;
    return {v, c};
  endfunction

  task automatic playSpan(int L, int bits, int h, int lo, int hi);
    for (int m = lo; m < hi; m++) begin
      @(negedge clk);
      mclk = 1'b1;
      fclk = (m < L / 2) ? 1'b0 : 1'b1;
      bclk = (((m * 2 * bits) / L) % 2) != 0;
      repeat (h - 1) @(negedge clk);
      @(negedge clk);
      mclk = 1'b0;
      repeat (h - 1) @(negedge clk);
    end
  endtask

  task automatic goIdle();
    @(negedge clk);
    mclk = 1'b0; bclk = 1'b0; fclk = 1'b1;
    repeat (200) @(negedge clk);
    check("R9 no early stop", clockStopped, 0);
    repeat (100) @(negedge clk);
    check("R9 stopped", clockStopped, 1);
    check("R9 stop drops lock", locked, 0);
  endtask

  // restart from idle, play three frames then half of the fourth
  task automatic lockRun(string req, int L, int bits, int h);
    logic [3:0] e = expect_cfg(L, bits, h);
    for (int f = 0; f < 3; f++) playSpan(L, bits, h, 0, L);
    check("R2 not yet locked", locked, 0);
    check("R9 stop released", clockStopped, 0);
    playSpan(L, bits, h, 0, L / 2);
    check({req, " lock"}, locked, int'(e[3]));
    if (e[3]) held = e[2:0];
    check({req, " cfg"}, int'(cfgNow()), int'(held));
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1 locked", locked, 0);
    check("R1 stopped", clockStopped, 0);
    check("R1 cfg", int'(cfgNow()), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({locked, clockStopped, cfgNow()}), 0);

    goIdle();
    lockRun("R4 256 slow", 256, 64, 2);
    goIdle();
    lockRun("R4 256 fast", 256, 64, 1);
    goIdle();
    lockRun("R4 384 slow", 384, 48, 2);
    goIdle();
    lockRun("R3 768", 768, 48, 1);
    goIdle();
    lockRun("R6 258", 258, 64, 2);
    // invalid cases: lock low, outputs held
    goIdle();
    lockRun("R10 128 slow", 128, 64, 4);
    goIdle();
    lockRun("R5 48 bits on 256", 256, 48, 2);
    goIdle();
    lockRun("R6 259", 259, 64, 2);
    check("R7 hold", int'(cfgNow()), 3'b000);

    // R8: locked on 256 slow, then switch to 512
    goIdle();
    lockRun("R8 base", 256, 64, 2);
    playSpan(256, 64, 2, 128, 256);
    playSpan(512, 64, 1, 0, 512);
    playSpan(512, 64, 1, 0, 256);
    check("R8 lock dropped", locked, 0);
    check("R8 cfg held", int'(cfgNow()), 3'b000);
    playSpan(512, 64, 1, 256, 512);
    playSpan(512, 64, 1, 0, 512);
    playSpan(512, 64, 1, 0, 256);
    check("R8 relocked", locked, 1);
    check("R3 512", int'(cfgNow()), 3'b010);

    // random legal configurations
    for (int it = 0; it < 8; it++) begin
      int legal[6] = '{128, 192, 256, 384, 512, 768};
      int r = legal[$urandom % 6];
      bit tri3 = (r % 3) == 0;
      int bits = (tri3 && ($urandom % 2 == 1)) ? 48 : 64;
      int h = (r == 256 || r == 384) ? int'($urandom % 2) + 1 : 1;
      int L = r + int'($urandom % 5) - 2;
      goIdle();
      lockRun("R3 random", L, bits, h);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule